// File: doc/BRIEF.md
# Multi-Context Receive Copy Dispatcher

This block shares one packet store and one DMA copy engine among several receive contexts. Software hands a context a 64-bit receive descriptor, which names a destination buffer and how many bytes it can take. The context is then marked busy and joins one of two work queues. A context that has no packet yet joins the fresh-request queue. A context that is still holding a partly copied packet joins the resume queue.

A single scheduler serves one context at a time. Resume requests always go first. A fresh request waits until the packet store holds a packet, and then claims the oldest unclaimed one. The scheduler issues one copy to the DMA port. When the copy is acknowledged, it writes a 32-bit completion word for the context, frees the context, and pulses a completion interrupt.

A copy moves at most the descriptor length and never more than the packet has left. A packet that does not fit stays bound to its context, and the next descriptor for that context resumes at the advanced offset. Packet lengths enter through a valid/ready stream, which stalls while the store is full. The DMA port holds its request and fields steady until it receives an acknowledge.

Top module: `rx_copy_dispatch`

## Requirements
- R1: The descriptor layout is: bits 39:0 hold the buffer address, bits 59:40 hold the requested length, and bit 60 is a virtual-address flag. Bits 63:61 are ignored. These fields appear on `dma_addr`, bound the value on `dma_len`, and appear on `dma_virt`.
- R2: A descriptor written to a context that is still busy is rejected. `desc_err` pulses high in the cycle after the write. The context's completion word is unchanged. No extra copy results.
- R3: An accepted descriptor write sets the context's completion word to 0x8000_0000 (bit 31, busy only). The new value is readable on `rd_done` in the next cycle.
- R4: A context with no bound packet joins the fresh queue. A context with a partly copied packet joins the resume queue. Each queue is served in arrival order.
- R5: When the scheduler looks for work, the head of the resume queue wins over any fresh request. This holds even when the fresh request was written earlier.
- R6: A fresh request is served only when the packet store is not empty. It binds the oldest stored packet to the context with offset 0, and no copy is issued while the store is empty.
- R7: The copy length is the smaller of the descriptor length and the bytes the packet still holds. `dma_req` and its fields stay constant until `dma_ack` is sampled high.
- R8: A descriptor address equal to 1 issues no DMA request. It goes straight to completion handling with the same length rules.
- R9: When a copy drains the packet, the completion word is 0x4000_0000 (bit 30) ORed with the copied length in bits 19:0. The packet binding is released, so the context's next descriptor is a fresh request.
- R10: When bytes remain after a copy, the completion word has bit 30 and bit 29 set and the remaining byte count in bits 19:0. The packet offset advances by the copied length.
- R11: Each completion raises `irq_rx_dma` for exactly one cycle. During that cycle, `done_ctx` and `done_word` carry the completion. The busy bit is cleared in the stored word.
- R12: `pkt_ready` is high while the packet store holds fewer than PKT_DEPTH lengths. A length is stored on each cycle where `pkt_valid` and `pkt_ready` are both high.
- R13: The work queues are each NUM_CTX deep and can never overflow, because a busy context cannot be queued twice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| desc_wr | input | 1 | Descriptor write strobe |
| desc_ctx | input | CTX_W | Target context of the descriptor write |
| desc_data | input | 64 | Receive descriptor |
| desc_err | output | 1 | Pulse: write hit a busy context |
| pkt_valid | input | 1 | Packet length offered to the store |
| pkt_ready | output | 1 | Store has room for a length |
| pkt_len | input | 20 | Byte length of the arriving packet |
| dma_req | output | 1 | Copy request, held until acknowledged |
| dma_ack | input | 1 | Copy finished |
| dma_ctx | output | CTX_W | Context being served |
| dma_addr | output | 40 | Destination buffer address |
| dma_len | output | 20 | Bytes to copy |
| dma_offset | output | 20 | Byte offset inside the packet |
| dma_virt | output | 1 | Address is virtual |
| irq_rx_dma | output | 1 | One-cycle completion pulse |
| done_ctx | output | CTX_W | Context of the completion |
| done_word | output | 32 | Completion word written |
| rd_ctx | input | CTX_W | Context whose completion word is read |
| rd_done | output | 32 | Completion word of `rd_ctx` |

## Verification
Most wrong internal states in this block show up in the next copy, a few cycles after the request is served. A stale binding or offset appears on `dma_offset`. A bad remaining count appears as a wrong length or a wrong bit 29 in `done_word`. A queue mix-up shows as DMA requests arriving in a different context order than the writes predict. A busy flag that never clears surfaces only at the next descriptor write to that context, as a spurious `desc_err`. The read-back port exposes a missing busy word one cycle after the write.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
  localparam int ADDR_W       = 40;
  localparam int LEN_W        = 20;
  localparam int DESC_LEN_LSB = 40;
  localparam int DESC_VIRT    = 60;
  localparam int WORD_W       = 32;
  localparam int WB_BUSY      = 31;
  localparam int WB_CPL       = 30;
  localparam int WB_MORE      = 29;
  localparam logic [ADDR_W-1:0] SKIP_ADDR = ADDR_W'(1);

  typedef enum logic [1:0] {
    RXD_IDLE,
    RXD_WAIT,
    RXD_COPY,
    RXD_DONE
  } rxd_state_e;

  function automatic logic [WORD_W-1:0] busy_word();
    logic [WORD_W-1:0] w;
    w = '0;
    w[WB_BUSY] = 1'b1;
    return w;
  endfunction
endpackage

// File: rtl/rxd_fifo.sv
module rxd_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign empty = (cnt == '0);
  assign full  = (cnt == CW'(DEPTH));
  assign dout  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push) wr_ptr <= nxt(wr_ptr);
      if (pop)  rd_ptr <= nxt(rd_ptr);
      case ({push, pop})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  // R13: a queue entry is never written into a full queue
  p_no_overflow_r13: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  p_no_underflow_r13: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/rxd_len_unit.sv
module rxd_len_unit
  import rxd_pkg::*;
(
  input  logic [LEN_W-1:0]  avail,
  input  logic [LEN_W-1:0]  req_len,
  output logic [LEN_W-1:0]  copy_len,
  input  logic [LEN_W-1:0]  rem,
  input  logic [LEN_W-1:0]  off,
  input  logic [LEN_W-1:0]  cur_len,
  output logic              last,
  output logic [LEN_W-1:0]  rem_next,
  output logic [LEN_W-1:0]  off_next,
  output logic [WORD_W-1:0] word
);
  localparam int PAD_W = WORD_W - 3 - LEN_W;

  always_comb begin
    copy_len = (avail < req_len) ? avail : req_len;
    last     = (rem == cur_len);
    rem_next = last ? '0 : rem - cur_len;
    off_next = off + cur_len;
    word     = {1'b0, 1'b1, !last, {PAD_W{1'b0}}, (last ? cur_len : rem_next)};
  end
endmodule

// File: rtl/rx_copy_dispatch.sv
module rx_copy_dispatch
  import rxd_pkg::*;
#(
  parameter int NUM_CTX   = 4,
  parameter int PKT_DEPTH = 8,
  parameter int CTX_W     = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              desc_wr,
  input  logic [CTX_W-1:0]  desc_ctx,
  input  logic [63:0]       desc_data,
  output logic              desc_err,
  input  logic              pkt_valid,
  output logic              pkt_ready,
  input  logic [LEN_W-1:0]  pkt_len,
  output logic              dma_req,
  input  logic              dma_ack,
  output logic [CTX_W-1:0]  dma_ctx,
  output logic [ADDR_W-1:0] dma_addr,
  output logic [LEN_W-1:0]  dma_len,
  output logic [LEN_W-1:0]  dma_offset,
  output logic              dma_virt,
  output logic              irq_rx_dma,
  output logic [CTX_W-1:0]  done_ctx,
  output logic [WORD_W-1:0] done_word,
  input  logic [CTX_W-1:0]  rd_ctx,
  output logic [WORD_W-1:0] rd_done
);
  rxd_state_e state;

  logic [NUM_CTX-1:0] ctx_busy, ctx_bound, ctx_virt;
  logic [ADDR_W-1:0]  ctx_addr [NUM_CTX];
  logic [LEN_W-1:0]   ctx_len  [NUM_CTX];
  logic [LEN_W-1:0]   ctx_rem  [NUM_CTX];
  logic [LEN_W-1:0]   ctx_off  [NUM_CTX];
  logic [WORD_W-1:0]  done_mem [NUM_CTX];

  logic [CTX_W-1:0] cur_ctx;
  logic [LEN_W-1:0] cur_len;

  logic accept, newq_push, contq_push, take_new, take_cont;
  logic newq_empty, newq_full, contq_empty, contq_full;
  logic pkt_empty, pkt_full, pkt_push;
  logic [CTX_W-1:0] newq_head, contq_head, sel_ctx;
  logic [LEN_W-1:0] pkt_head, avail, issue_len;
  logic             fin_last;
  logic [LEN_W-1:0] fin_rem, fin_off;
  logic [WORD_W-1:0] fin_word;
  logic unused_desc_bits;

  assign unused_desc_bits = ^desc_data[63:61];

  assign accept     = desc_wr && !ctx_busy[desc_ctx];
  assign newq_push  = accept && !ctx_bound[desc_ctx];
  assign contq_push = accept &&  ctx_bound[desc_ctx];
  assign take_cont  = (state == RXD_WAIT) && !contq_empty;
  assign take_new   = (state == RXD_WAIT) && contq_empty && !newq_empty && !pkt_empty;
  assign sel_ctx    = take_cont ? contq_head : newq_head;
  assign avail      = take_cont ? ctx_rem[sel_ctx] : pkt_head;
  assign pkt_ready  = !pkt_full;
  assign pkt_push   = pkt_valid && pkt_ready;

  rxd_fifo #(.W(CTX_W), .DEPTH(NUM_CTX)) u_newq (
    .clk(clk), .rst_n(rst_n), .push(newq_push), .din(desc_ctx), .pop(take_new),
    .dout(newq_head), .empty(newq_empty), .full(newq_full));

  rxd_fifo #(.W(CTX_W), .DEPTH(NUM_CTX)) u_contq (
    .clk(clk), .rst_n(rst_n), .push(contq_push), .din(desc_ctx), .pop(take_cont),
    .dout(contq_head), .empty(contq_empty), .full(contq_full));

  rxd_fifo #(.W(LEN_W), .DEPTH(PKT_DEPTH)) u_pkts (
    .clk(clk), .rst_n(rst_n), .push(pkt_push), .din(pkt_len), .pop(take_new),
    .dout(pkt_head), .empty(pkt_empty), .full(pkt_full));

  rxd_len_unit u_len (
    .avail(avail), .req_len(ctx_len[sel_ctx]), .copy_len(issue_len),
    .rem(ctx_rem[cur_ctx]), .off(ctx_off[cur_ctx]), .cur_len(cur_len),
    .last(fin_last), .rem_next(fin_rem), .off_next(fin_off), .word(fin_word));

  assign dma_req    = (state == RXD_COPY);
  assign dma_ctx    = cur_ctx;
  assign dma_addr   = ctx_addr[cur_ctx];
  assign dma_len    = cur_len;
  assign dma_offset = ctx_off[cur_ctx];
  assign dma_virt   = ctx_virt[cur_ctx];
  assign rd_done    = done_mem[rd_ctx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= RXD_IDLE;
      ctx_busy   <= '0;
      ctx_bound  <= '0;
      ctx_virt   <= '0;
      cur_ctx    <= '0;
      cur_len    <= '0;
      desc_err   <= 1'b0;
      irq_rx_dma <= 1'b0;
      done_ctx   <= '0;
      done_word  <= '0;
      for (int i = 0; i < NUM_CTX; i++) begin
        done_mem[i] <= '0;
        ctx_rem[i]  <= '0;
        ctx_off[i]  <= '0;
        ctx_addr[i] <= '0;
        ctx_len[i]  <= '0;
      end
    end else begin
      irq_rx_dma <= 1'b0;
      desc_err   <= desc_wr && ctx_busy[desc_ctx];

      if (accept) begin
        ctx_busy[desc_ctx] <= 1'b1;
        ctx_addr[desc_ctx] <= desc_data[ADDR_W-1:0];
        ctx_len[desc_ctx]  <= desc_data[DESC_LEN_LSB +: LEN_W];
        ctx_virt[desc_ctx] <= desc_data[DESC_VIRT];
        done_mem[desc_ctx] <= busy_word();
      end

      case (state)
        RXD_IDLE: if (!newq_empty || !contq_empty) state <= RXD_WAIT;
        RXD_WAIT: begin
          if (take_cont || take_new) begin
            cur_ctx <= sel_ctx;
            cur_len <= issue_len;
            if (take_new) begin
              ctx_rem[sel_ctx]   <= pkt_head;
              ctx_off[sel_ctx]   <= '0;
              ctx_bound[sel_ctx] <= 1'b1;
            end
            state <= (ctx_addr[sel_ctx] == SKIP_ADDR) ? RXD_DONE : RXD_COPY;
          end
        end
        RXD_COPY: if (dma_ack) state <= RXD_DONE;
        RXD_DONE: begin
          done_mem[cur_ctx] <= fin_word;
          ctx_busy[cur_ctx] <= 1'b0;
          ctx_rem[cur_ctx]  <= fin_rem;
          ctx_off[cur_ctx]  <= fin_off;
          if (fin_last) ctx_bound[cur_ctx] <= 1'b0;
          irq_rx_dma <= 1'b1;
          done_ctx   <= cur_ctx;
          done_word  <= fin_word;
          state <= (newq_empty && contq_empty) ? RXD_IDLE : RXD_WAIT;
        end
        default: state <= RXD_IDLE;
      endcase
    end
  end

  // R2: a rejected write leaves the stored completion word alone
  p_reject_keeps_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_wr && ctx_busy[desc_ctx] && !(state == RXD_DONE && cur_ctx == desc_ctx))
    |=> done_mem[$past(desc_ctx)] == $past(done_mem[desc_ctx]));
  // R3: accepted write shows the busy-only word next cycle
  p_busy_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> done_mem[$past(desc_ctx)] == busy_word());
  // R7: request and fields hold until acknowledged
  p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req && !dma_ack) |=> dma_req && $stable(dma_addr) && $stable(dma_len)
      && $stable(dma_offset) && $stable(dma_ctx));
  // R8: the skip address never reaches the DMA port
  p_skip_no_dma_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> dma_addr != SKIP_ADDR);
  // R11: completion interrupt is a single-cycle pulse
  p_irq_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rx_dma |=> !irq_rx_dma);
  // R13: a queued context is always busy
  p_queue_once_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !newq_empty |-> ctx_busy[newq_head]);
endmodule

// File: tb/rx_copy_dispatch_tb_top.sv
module rx_copy_dispatch_tb_top;
  localparam int NCTX = 4;
  localparam int PDEP = 8;
  localparam logic [31:0] W_BUSY = 32'h8000_0000;
  localparam logic [31:0] W_CPL  = 32'h4000_0000;
  localparam logic [31:0] W_MORE = 32'h2000_0000;

  typedef struct {
    logic [1:0]  ctx;
    logic [39:0] addr;
    logic [19:0] len;
    logic [19:0] off;
    logic        virt;
  } dma_exp_t;

  typedef struct {
    logic [1:0]  ctx;
    logic [31:0] word;
  } done_exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic desc_wr = 1'b0;
  logic [1:0] desc_ctx = '0;
  logic [63:0] desc_data = '0;
  logic desc_err;
  logic pkt_valid = 1'b0;
  logic pkt_ready;
  logic [19:0] pkt_len = '0;
  logic dma_req;
  logic dma_ack = 1'b0;
  logic [1:0] dma_ctx;
  logic [39:0] dma_addr;
  logic [19:0] dma_len, dma_offset;
  logic dma_virt;
  logic irq_rx_dma;
  logic [1:0] done_ctx;
  logic [31:0] done_word;
  logic [1:0] rd_ctx = '0;
  logic [31:0] rd_done;

  int n_run = 0;
  int n_fail = 0;
  dma_exp_t  dma_q[$];
  done_exp_t done_q[$];

  always #4 clk = ~clk;

  rx_copy_dispatch #(.NUM_CTX(NCTX), .PKT_DEPTH(PDEP)) dut_i (
    .clk(clk), .rst_n(rst_n), .desc_wr(desc_wr), .desc_ctx(desc_ctx),
    .desc_data(desc_data), .desc_err(desc_err), .pkt_valid(pkt_valid),
    .pkt_ready(pkt_ready), .pkt_len(pkt_len), .dma_req(dma_req), .dma_ack(dma_ack),
    .dma_ctx(dma_ctx), .dma_addr(dma_addr), .dma_len(dma_len), .dma_offset(dma_offset),
    .dma_virt(dma_virt), .irq_rx_dma(irq_rx_dma), .done_ctx(done_ctx),
    .done_word(done_word), .rd_ctx(rd_ctx), .rd_done(rd_done));

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push_pkt(input logic [19:0] len);
    @(negedge clk);
    pkt_valid = 1'b1;
    pkt_len = len;
    @(negedge clk);
    pkt_valid = 1'b0;
  endtask

  task automatic write_desc(input logic [1:0] c, input bit virt,
                            input logic [39:0] addr, input logic [19:0] len);
    @(negedge clk);
    desc_wr = 1'b1;
    desc_ctx = c;
    desc_data = {3'b000, virt, len, addr};
    @(posedge clk);
    #1;
    desc_wr = 1'b0;
  endtask

  task automatic exp_dma(input logic [1:0] c, input logic [39:0] a,
                         input logic [19:0] l, input logic [19:0] o, input bit v);
    dma_exp_t e;
    e.ctx = c; e.addr = a; e.len = l; e.off = o; e.virt = v;
    dma_q.push_back(e);
  endtask

  task automatic exp_done(input logic [1:0] c, input logic [31:0] w);
    done_exp_t e;
    e.ctx = c; e.word = w;
    done_q.push_back(e);
  endtask

  task automatic drain();
    while (dma_q.size() != 0 || done_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic read_word(input logic [1:0] c, input logic [31:0] exp, input string tag);
    @(negedge clk);
    rd_ctx = c;
    #1;
    check(rd_done == exp, tag, rd_done, exp);
  endtask

  // DMA responder and monitor (R1, R7)
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && dma_req && !dma_ack) begin
        if (dma_q.size() == 0) begin
          check(1'b0, "R8 unexpected DMA request", dma_addr, 0);
        end else begin
          dma_exp_t e;
          e = dma_q.pop_front();
          check(dma_ctx == e.ctx && dma_addr == e.addr, "R1 dma ctx/addr",
                {dma_ctx, dma_addr}, {e.ctx, e.addr});
          check(dma_len == e.len, "R7 dma length", dma_len, e.len);
          check(dma_offset == e.off && dma_virt == e.virt, "R10 dma offset/virt",
                {dma_virt, dma_offset}, {e.virt, e.off});
        end
        repeat (2) begin
          @(negedge clk);
          check(dma_req == 1'b1, "R7 request held", dma_req, 1);
        end
        dma_ack = 1'b1;
        @(negedge clk);
        dma_ack = 1'b0;
      end
    end
  end

  // Completion monitor (R9, R10, R11)
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && irq_rx_dma) begin
        if (done_q.size() == 0) begin
          check(1'b0, "R11 unexpected completion", done_word, 0);
        end else begin
          done_exp_t e;
          e = done_q.pop_front();
          check(done_ctx == e.ctx && done_word == e.word, "R9/R10 completion word",
                {done_ctx, done_word}, {e.ctx, e.word});
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    check(dma_req == 0 && irq_rx_dma == 0 && desc_err == 0, "R11 reset outputs quiet",
          {dma_req, irq_rx_dma, desc_err}, 0);
    check(pkt_ready == 1, "R12 ready after reset", pkt_ready, 1);
    for (int c = 0; c < NCTX; c++) read_word(2'(c), 32'h0, "R3 reset word zero");

    // partial copy then resume
    push_pkt(20'd100);
    exp_dma(2'd0, 40'h1000, 20'd64, 20'd0, 1'b0);
    exp_done(2'd0, W_CPL | W_MORE | 32'd36);
    write_desc(2'd0, 1'b0, 40'h1000, 20'd64);
    check(desc_err == 0, "R2 no error on idle context", desc_err, 0);
    rd_ctx = 2'd0;
    #1;
    check(rd_done == W_BUSY, "R3 busy word after write", rd_done, W_BUSY);
    drain();
    read_word(2'd0, W_CPL | W_MORE | 32'd36, "R11 stored word busy cleared");

    exp_dma(2'd0, 40'h2000, 20'd36, 20'd64, 1'b1);
    exp_done(2'd0, W_CPL | 32'd36);
    write_desc(2'd0, 1'b1, 40'h2000, 20'd64);
    drain();

    // resume wins over an earlier fresh request (R5)
    push_pkt(20'd200);
    exp_dma(2'd1, 40'h3000, 20'd50, 20'd0, 1'b0);
    exp_done(2'd1, W_CPL | W_MORE | 32'd150);
    write_desc(2'd1, 1'b0, 40'h3000, 20'd50);
    drain();
    push_pkt(20'd30);
    exp_dma(2'd1, 40'h4000, 20'd150, 20'd50, 1'b0);
    exp_done(2'd1, W_CPL | 32'd150);
    exp_dma(2'd2, 40'h5000, 20'd30, 20'd0, 1'b0);
    exp_done(2'd2, W_CPL | 32'd30);
    write_desc(2'd2, 1'b0, 40'h5000, 20'd40);
    write_desc(2'd1, 1'b0, 40'h4000, 20'd150);
    drain();
    check(dma_q.size() == 0, "R5 resume served first", dma_q.size(), 0);

    // fresh request waits for a packet; busy rewrite rejected (R6, R2)
    write_desc(2'd3, 1'b0, 40'h6000, 20'd40);
    repeat (10) @(negedge clk);
    check(dma_req == 0, "R6 no copy while store empty", dma_req, 0);
    write_desc(2'd3, 1'b0, 40'h7000, 20'd8);
    check(desc_err == 1, "R2 busy write flagged", desc_err, 1);
    read_word(2'd3, W_BUSY, "R2 word unchanged after reject");
    exp_dma(2'd3, 40'h6000, 20'd20, 20'd0, 1'b0);
    exp_done(2'd3, W_CPL | 32'd20);
    push_pkt(20'd20);
    drain();

    // skip address (R8)
    push_pkt(20'd10);
    exp_done(2'd0, W_CPL | 32'd10);
    write_desc(2'd0, 1'b0, 40'h1, 20'd16);
    drain();
    read_word(2'd0, W_CPL | 32'd10, "R8 skip completion stored");

    // fresh queue order and packet binding order (R4, R6)
    push_pkt(20'd11);
    push_pkt(20'd22);
    push_pkt(20'd33);
    push_pkt(20'd44);
    for (int c = 0; c < NCTX; c++) begin
      exp_dma(2'(c), 40'(32'h100 * (c + 1)), 20'(11 * (c + 1)), 20'd0, 1'b0);
      exp_done(2'(c), W_CPL | 32'(11 * (c + 1)));
    end
    for (int c = 0; c < NCTX; c++) write_desc(2'(c), 1'b0, 40'(32'h100 * (c + 1)), 20'd100);
    drain();
    check(done_q.size() == 0, "R4 all fresh requests served", done_q.size(), 0);

    // packet store back-pressure (R12)
    for (int k = 0; k < PDEP - 1; k++) push_pkt(20'(k + 1));
    @(negedge clk);
    check(pkt_ready == 1, "R12 ready with one slot left", pkt_ready, 1);
    push_pkt(20'd9);
    @(negedge clk);
    check(pkt_ready == 0, "R12 not ready when full", pkt_ready, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule